// File: doc/BRIEF.md
# Two-Level Tree Priority Selector

This block picks one data word out of sixteen candidates. Each candidate has its own valid bit, and any number of valid bits may be set together. The lowest-numbered valid candidate always wins. When nothing is valid, the output takes a fixed error value, and a flag shows that no candidate was present.

The priority decision is not a sixteen-deep if/else chain. Four first-stage selectors each resolve four neighbouring candidates. A last four-way selector then picks among the four stage results, using the OR of each group's valid bits as that group's request. The logic depth therefore grows with two small selectors rather than with the full candidate count.

Because the groups are always square, the tree stays two levels deep. The decision is made in one cycle between registers. The output register stage can be removed with a parameter. The block also reports which candidate won, as an index: the high part is the group number and the low part is the slot inside that group.

Top module: `prio_tree_sel`

## Requirements
- R1: Candidate k drives bits `data_i[k*8 +: 8]` and request bit `valid_i[k]`. When at least one request is set, `data_o` equals the data of the lowest-numbered set request.
- R2: A lower-numbered candidate wins over any higher-numbered one, whatever the higher request bits are. With all sixteen set, candidate 0 wins.
- R3: When no request bit is set, `data_o` equals the error value `ERR_VAL` (default 8'h00), `idx_o` is 0 and `any_valid_o` is 0.
- R4: `any_valid_o` is the OR of all sixteen request bits.
- R5: `idx_o` is the 4-bit number of the winning candidate. Bits [3:2] give the winning group and bits [1:0] give the slot inside that group.
- R6: With the default `REG_OUT=1`, the outputs show the inputs present at a rising edge of `clk_i` just after that edge. While `rst_ni` is low, the outputs hold `ERR_VAL`, index 0 and flag 0.
- R7: For every one of the 65536 request patterns, the outputs equal those of a flat lowest-index-first priority chain, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 128 | Sixteen candidate words; candidate k sits at [k*8 +: 8] |
| valid_i | input | 16 | One request bit per candidate |
| data_o | output | 8 | Data of the winner, or ERR_VAL |
| idx_o | output | 4 | Number of the winner: {group, slot}; 0 when none |
| any_valid_o | output | 1 | High when any request bit is set |

## Verification
Every result is due one cycle after its stimulus. The bench drives the inputs on a falling edge, and the rising edge that follows captures the selection. The bench then reads all three outputs on the next falling edge, before it drives the next pattern. So each pattern takes exactly one cycle and is checked in the cycle where it is due. The reset values are read on a falling edge while reset is still held low.

// File: rtl/prio_tree_pkg.sv
package prio_tree_pkg;
  // bits needed to number n slots, never less than one
  function automatic int unsigned slot_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/grp_prio_sel.sv
module grp_prio_sel #(
  parameter int unsigned W     = 8,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned PW   = prio_tree_pkg::slot_bits(WAYS)
) (
  input  logic [WAYS*W-1:0] data_i,
  input  logic [WAYS-1:0]   valid_i,
  output logic [W-1:0]      data_o,
  output logic              hit_o,
  output logic [PW-1:0]     pos_o
);
  logic [PW-1:0] pos;

  // scan from the top so the lowest set slot is written last
  always_comb begin
    pos = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (valid_i[i]) pos = PW'(i);
    end
  end

  assign pos_o  = pos;
  assign hit_o  = |valid_i;
  assign data_o = data_i[pos*W +: W];
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned   DW      = 8,
  parameter int unsigned   IW      = 4,
  parameter bit            REG_OUT = 1'b1,
  parameter logic [DW-1:0] ERR_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_d,
  input  logic [IW-1:0] idx_d,
  input  logic          any_d,
  output logic [DW-1:0] data_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o <= ERR_VAL;
        idx_o  <= '0;
        any_o  <= 1'b0;
      end else begin
        data_o <= data_d;
        idx_o  <= idx_d;
        any_o  <= any_d;
      end
    end
  end else begin : g_comb
    assign data_o = data_d;
    assign idx_o  = idx_d;
    assign any_o  = any_d;
  end
endmodule

// File: rtl/prio_tree_sel.sv
module prio_tree_sel #(
  parameter int unsigned       DATA_W  = 8,
  parameter int unsigned       GRP_W   = 4,
  parameter logic [DATA_W-1:0] ERR_VAL = '0,
  parameter bit                REG_OUT = 1'b1,
  localparam int unsigned      N       = GRP_W * GRP_W,
  localparam int unsigned      POS_W   = prio_tree_pkg::slot_bits(GRP_W),
  localparam int unsigned      IDX_W   = 2 * POS_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N*DATA_W-1:0] data_i,
  input  logic [N-1:0]        valid_i,
  output logic [DATA_W-1:0]   data_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                any_valid_o
);
  localparam int unsigned PAY_W = DATA_W + POS_W;

  logic [GRP_W-1:0][PAY_W-1:0] grp_pay;
  logic [GRP_W-1:0]            grp_hit;

  // first level: one selector per group, carrying its slot number with the data
  for (genvar g = 0; g < GRP_W; g++) begin : g_grp
    logic [DATA_W-1:0] g_data;
    logic [POS_W-1:0]  g_pos;
    grp_prio_sel #(.W(DATA_W), .WAYS(GRP_W)) u_grp (
      .data_i (data_i[g*GRP_W*DATA_W +: GRP_W*DATA_W]),
      .valid_i(valid_i[g*GRP_W +: GRP_W]),
      .data_o (g_data),
      .hit_o  (grp_hit[g]),
      .pos_o  (g_pos)
    );
    assign grp_pay[g] = {g_data, g_pos};
  end

  // second level: group-OR requests pick one group payload
  logic [PAY_W-1:0] fin_pay;
  logic             fin_hit;
  logic [POS_W-1:0] fin_pos;

  grp_prio_sel #(.W(PAY_W), .WAYS(GRP_W)) u_fin (
    .data_i (grp_pay),
    .valid_i(grp_hit),
    .data_o (fin_pay),
    .hit_o  (fin_hit),
    .pos_o  (fin_pos)
  );

  logic [DATA_W-1:0] sel_data;
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_any;

  assign sel_any  = fin_hit;
  assign sel_data = fin_hit ? fin_pay[PAY_W-1:POS_W] : ERR_VAL;
  assign sel_idx  = fin_hit ? {fin_pos, fin_pay[POS_W-1:0]} : '0;

  out_stage #(.DW(DATA_W), .IW(IDX_W), .REG_OUT(REG_OUT), .ERR_VAL(ERR_VAL)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_d(sel_data),
    .idx_d (sel_idx),
    .any_d (sel_any),
    .data_o(data_o),
    .idx_o (idx_o),
    .any_o (any_valid_o)
  );

  assert_win_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_any |-> sel_data == data_i[sel_idx*DATA_W +: DATA_W]);

  assert_win_lowest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_any |-> (valid_i[sel_idx] &&
                 (valid_i & ((N'(1) << sel_idx) - N'(1))) == '0));

  assert_none_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) |-> (sel_data == ERR_VAL && sel_idx == '0));

  assert_any_or_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_any == (valid_i != '0));

  assert_out_none_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_valid_o |-> (data_o == ERR_VAL && idx_o == '0));
endmodule

// File: tb/prio_tree_sel_tb_top.sv
module prio_tree_sel_tb_top;
  localparam int N  = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N*DW-1:0] data_i = '0;
  logic [N-1:0]  valid_i = '0;
  logic [DW-1:0] data_o;
  logic [3:0]    idx_o;
  logic          any_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2ns clk = ~clk;

  prio_tree_sel dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .data_o(data_o), .idx_o(idx_o), .any_valid_o(any_valid_o)
  );

  // flat chain reference: index of lowest set bit, -1 when none
  function automatic int ref_win(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] v, string tag);
    int w;
    valid_i = v;
    for (int i = 0; i < N; i++) data_i[i*DW +: DW] = DW'($urandom);
    @(negedge clk);
    w = ref_win(v);
    if (w < 0) begin
      chk({tag, " R3 data"}, 32'(data_o), 32'h00);
      chk({tag, " R3 idx"}, 32'(idx_o), 32'h0);
      chk({tag, " R4 any"}, 32'(any_valid_o), 32'h0);
    end else begin
      chk({tag, " R1 data"}, 32'(data_o), 32'(data_i[w*DW +: DW]));
      chk({tag, " R5 idx"}, 32'(idx_o), 32'(w));
      chk({tag, " R4 any"}, 32'(any_valid_o), 32'h1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    valid_i = 16'hffff;
    repeat (3) @(negedge clk);
    chk("R6 reset data", 32'(data_o), 32'h00);
    chk("R6 reset idx", 32'(idx_o), 32'h0);
    chk("R6 reset any", 32'(any_valid_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    // directed corners
    apply(16'hffff, "R2 all set");
    apply(16'h8000, "R1 last only");
    apply(16'h0000, "R3 none");
    apply(16'h0010, "R5 group1 slot0");
    apply(16'h0018, "R2 group edge");
    apply(16'hf000, "R2 top group");
    apply(16'h0c00, "R5 group2 slot2");
    apply(16'h0000, "R3 none again");
    // random patterns
    for (int k = 0; k < 500; k++) apply(16'($urandom), "R2 random");
    // exhaustive against flat chain
    for (int p = 0; p < 65536; p++) apply(16'(p), "R7 sweep");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule